// File: doc/BRIEF.md
# Ternary Lookup Table with Host Access

This block is a ternary content-addressable store. Every entry keeps a stored word, a care word of the same width and a single occupancy flag. A search key is checked against all entries in parallel. An entry matches when it is occupied and agrees with the key at every bit where its care word holds a 1. Care bits of 0 are wildcards. When more than one entry matches, the lowest-numbered entry is reported.

A host reaches any entry by index and uses one select line to choose between the stored-word plane and the care-word plane. A write puts the shared bus value into the chosen plane. A read returns the chosen plane's word, one cycle later, with its own strobe. Searches and host writes share the same wide bus, so they cannot happen in the same cycle. If both strobes are raised together, the write is performed, the search is discarded and an error pulse is raised.

A search is accepted only while the ready output is high. The ready output drops for the one cycle in which the lookup is evaluated. It rises again in the cycle where the hit flag and hit index are presented.

Top module: `tcam_lookup_top`

## Requirements
- R1: While reset is held and right after it is released, cmp_ready is 1, and hit, hit_idx, rd_valid and clash_err are 0. rd_data reads as pad ones over a zero word. Reset empties every entry, so a later search misses until the entries are written again.
- R2: A write with plane_sel = 0 stores key_data as the entry's stored word and marks the entry occupied. A write with plane_sel = 1 stores key_data as the entry's care word and leaves occupancy unchanged.
- R3: A read strobe sampled at a clock edge makes rd_valid 1 for exactly the following cycle. The low KEY_W bits of rd_data then hold the word at entry_idx from the plane chosen by plane_sel (0 = stored word, 1 = care word). A read in the same cycle as a write to the same entry returns the contents from before the write.
- R4: The top PAD_W bits of rd_data are always 1.
- R5: An entry matches a key when it is occupied and ((key XOR stored) AND care) is zero. Care bits of 0 never affect the result.
- R6: When several entries match, hit_idx is the lowest matching index.
- R7: An entry whose only write has been to its care plane never produces a hit.
- R8: A search accepted at an edge makes cmp_ready 0 for the next cycle, with hit and hit_idx still holding the previous result. At the following edge the new result appears and cmp_ready returns to 1. The result then holds until another search completes.
- R9: A search strobe sampled while cmp_ready is 0 is ignored.
- R10: When cmp_req and wr_req are both high at an edge, the write takes effect and the search is dropped, so cmp_ready stays 1. clash_err is 1 for exactly the following cycle.
- R11: On a miss, hit is 0 and hit_idx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_req | input | 1 | Search strobe |
| key_data | input | KEY_W | Search key or host write word |
| wr_req | input | 1 | Host write strobe |
| rd_req | input | 1 | Host read strobe |
| plane_sel | input | 1 | Plane for host access: 0 stored word, 1 care word |
| entry_idx | input | IDX_W | Entry index for host access |
| cmp_ready | output | 1 | High when a search can be accepted |
| hit | output | 1 | Last search found a match |
| hit_idx | output | IDX_W | Index of the winning entry, 0 on a miss |
| rd_valid | output | 1 | One-cycle strobe qualifying rd_data |
| rd_data | output | KEY_W+PAD_W | Read word with its top PAD_W bits set to 1 |
| clash_err | output | 1 | One-cycle pulse after a search and a write collide |

## Verification
The bench loads two identical fully-cared entries. A design that picks the highest match would report index 6 instead of 2. A partly-cared entry is hit by a key that differs only in wildcard bits, which a design ignoring the care plane would miss. An entry that has only a care word of all zeros would hit every key if writing the care plane wrongly marked it occupied. The collision test catches a design that lets the search through, by watching cmp_ready drop. A read that collides with a write must return the old word, not the new one. A second reset must turn a known hit back into a miss.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  typedef enum logic {
    PLANE_DATA = 1'b0,
    PLANE_MASK = 1'b1
  } plane_e;

endpackage

// File: rtl/tcam_guard.sv
module tcam_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_req,
  input  logic wr_req,
  input  logic cmp_ready,
  output logic cmp_go,
  output logic clash_q
);

  logic clash_now;

  // a search only proceeds when ready and not colliding with a host write
  assign clash_now = cmp_req && wr_req;
  assign cmp_go    = cmp_req && !wr_req && cmp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clash_q <= 1'b0;
    else        clash_q <= clash_now;
  end

endmodule

// File: rtl/tcam_store.sv
module tcam_store
  import tcam_pkg::*;
#(
  parameter int KEY_W   = 200,
  parameter int ENTRIES = 128,
  parameter int PAD_W   = 2,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic                            rd_en,
  input  plane_e                          plane,
  input  logic [IDX_W-1:0]                idx,
  input  logic [KEY_W-1:0]                wdata,
  output logic [ENTRIES-1:0][KEY_W-1:0]   data_q,
  output logic [ENTRIES-1:0][KEY_W-1:0]   mask_q,
  output logic [ENTRIES-1:0]              valid_q,
  output logic                            rd_valid,
  output logic [KEY_W+PAD_W-1:0]          rd_data
);

  localparam int RD_W = KEY_W + PAD_W;

  logic [KEY_W-1:0] rd_word_q;
  logic             rd_valid_q;
  logic [KEY_W-1:0] rd_pick;

  function automatic logic [KEY_W-1:0] pick_plane(
    input plane_e           p,
    input logic [KEY_W-1:0] dword,
    input logic [KEY_W-1:0] mword
  );
    return (p == PLANE_MASK) ? mword : dword;
  endfunction

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic             sel;
    logic [KEY_W-1:0] d_r;
    logic [KEY_W-1:0] m_r;
    logic             v_r;

    assign sel = (idx == IDX_W'(e));

    // array contents are not reset; only occupancy is
    always_ff @(posedge clk) begin
      if (wr_en && sel) begin
        if (plane == PLANE_MASK) m_r <= wdata;
        else                     d_r <= wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    v_r <= 1'b0;
      else if (wr_en && sel && plane == PLANE_DATA)  v_r <= 1'b1;
    end

    assign data_q[e]  = d_r;
    assign mask_q[e]  = m_r;
    assign valid_q[e] = v_r;
  end

  assign rd_pick = pick_plane(plane, data_q[idx], mask_q[idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_word_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rd_word_q <= rd_pick;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = RD_W'({{PAD_W{1'b1}}, rd_word_q});

endmodule

// File: rtl/tcam_match.sv
module tcam_match #(
  parameter int KEY_W   = 200,
  parameter int ENTRIES = 128,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmp_go,
  input  logic [KEY_W-1:0]              key,
  input  logic [ENTRIES-1:0][KEY_W-1:0] data_q,
  input  logic [ENTRIES-1:0][KEY_W-1:0] mask_q,
  input  logic [ENTRIES-1:0]            valid_q,
  output logic                          cmp_ready,
  output logic                          hit,
  output logic [IDX_W-1:0]              hit_idx
);

  logic [KEY_W-1:0]   key_q;
  logic               busy_q;
  logic [ENTRIES-1:0] match_vec;
  logic               any_match;
  logic [IDX_W-1:0]   win_idx;
  logic               hit_q;
  logic [IDX_W-1:0]   hit_idx_q;

  // ternary compare of one entry: differing bits only count where cared
  function automatic logic entry_hits(
    input logic [KEY_W-1:0] k,
    input logic [KEY_W-1:0] d,
    input logic [KEY_W-1:0] m,
    input logic             v
  );
    return v && (((k ^ d) & m) == '0);
  endfunction

  // lowest set bit wins
  function automatic logic [IDX_W-1:0] lowest_set(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match_vec[e] = entry_hits(key_q, data_q[e], mask_q[e], valid_q[e]);
  end

  assign any_match = |match_vec;
  assign win_idx   = any_match ? lowest_set(match_vec) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q     <= '0;
      busy_q    <= 1'b0;
      hit_q     <= 1'b0;
      hit_idx_q <= '0;
    end else begin
      busy_q <= cmp_go;
      if (cmp_go) key_q <= key;
      if (busy_q) begin
        hit_q     <= any_match;
        hit_idx_q <= win_idx;
      end
    end
  end

  assign cmp_ready = !busy_q;
  assign hit       = hit_q;
  assign hit_idx   = hit_idx_q;

endmodule

// File: rtl/tcam_lookup_top.sv
module tcam_lookup_top
  import tcam_pkg::*;
#(
  parameter int KEY_W   = 200,
  parameter int ENTRIES = 128,
  parameter int PAD_W   = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int RD_W   = KEY_W + PAD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_req,
  input  logic [KEY_W-1:0] key_data,
  input  logic             wr_req,
  input  logic             rd_req,
  input  logic             plane_sel,
  input  logic [IDX_W-1:0] entry_idx,
  output logic             cmp_ready,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic             rd_valid,
  output logic [RD_W-1:0]  rd_data,
  output logic             clash_err
);

  logic                          cmp_go;
  logic [ENTRIES-1:0][KEY_W-1:0] data_q;
  logic [ENTRIES-1:0][KEY_W-1:0] mask_q;
  logic [ENTRIES-1:0]            valid_q;
  plane_e                        plane;

  assign plane = plane_e'(plane_sel);

  tcam_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_req   (cmp_req),
    .wr_req    (wr_req),
    .cmp_ready (cmp_ready),
    .cmp_go    (cmp_go),
    .clash_q   (clash_err)
  );

  tcam_store #(
    .KEY_W   (KEY_W),
    .ENTRIES (ENTRIES),
    .PAD_W   (PAD_W),
    .IDX_W   (IDX_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_req),
    .rd_en    (rd_req),
    .plane    (plane),
    .idx      (entry_idx),
    .wdata    (key_data),
    .data_q   (data_q),
    .mask_q   (mask_q),
    .valid_q  (valid_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  tcam_match #(
    .KEY_W   (KEY_W),
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_go    (cmp_go),
    .key       (key_data),
    .data_q    (data_q),
    .mask_q    (mask_q),
    .valid_q   (valid_q),
    .cmp_ready (cmp_ready),
    .hit       (hit),
    .hit_idx   (hit_idx)
  );

endmodule

// File: rtl/tcam_lookup_chk.sv
module tcam_lookup_chk #(
  parameter int ENTRIES = 128,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmp_req,
  input logic               wr_req,
  input logic               rd_req,
  input logic               cmp_go,
  input logic               cmp_ready,
  input logic               hit,
  input logic [IDX_W-1:0]   hit_idx,
  input logic [ENTRIES-1:0] valid_q,
  input logic               rd_valid,
  input logic               clash_err
);

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_go |=> !cmp_ready);

  p_busy_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_ready |=> cmp_ready);

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_ready && $past(cmp_ready)) |-> ($stable(hit) && $stable(hit_idx)));

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_ready |-> !cmp_go);

  p_clash_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_req && wr_req) |=> clash_err);

  p_clash_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_req && wr_req) |=> !clash_err);

  p_clash_drops_search_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_req && wr_req) |=> cmp_ready);

  p_read_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  p_read_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  p_hit_is_occupied_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> valid_q[hit_idx]);

  p_miss_index_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_idx == '0));

endmodule

bind tcam_lookup_top tcam_lookup_chk #(
  .ENTRIES (ENTRIES),
  .IDX_W   (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_req   (cmp_req),
  .wr_req    (wr_req),
  .rd_req    (rd_req),
  .cmp_go    (cmp_go),
  .cmp_ready (cmp_ready),
  .hit       (hit),
  .hit_idx   (hit_idx),
  .valid_q   (valid_q),
  .rd_valid  (rd_valid),
  .clash_err (clash_err)
);

// File: tb/tcam_lookup_top_bench.sv
module tcam_lookup_top_bench;

  localparam int KEY_W   = 200;
  localparam int ENTRIES = 128;
  localparam int IDX_W   = 7;
  localparam int RD_W    = 202;

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_CM = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [6:0]  idx;
    logic        plane;
    logic [31:0] seed;
    logic        ehit;
    logic [6:0]  eidx;
  } row_t;

  localparam int NROWS = 18;
  localparam row_t TBL [NROWS] = '{
    '{OP_WR, 7'd2,  1'b1, 32'hFFFF_FFFF, 1'b0, 7'd0},
    '{OP_WR, 7'd2,  1'b0, 32'hA5A5_0F0F, 1'b0, 7'd0},
    '{OP_WR, 7'd6,  1'b1, 32'hFFFF_FFFF, 1'b0, 7'd0},
    '{OP_WR, 7'd6,  1'b0, 32'hA5A5_0F0F, 1'b0, 7'd0},
    '{OP_WR, 7'd9,  1'b1, 32'hFFFF_0000, 1'b0, 7'd0},
    '{OP_WR, 7'd9,  1'b0, 32'h1357_9BDF, 1'b0, 7'd0},
    '{OP_WR, 7'd3,  1'b1, 32'h0000_0000, 1'b0, 7'd0},
    '{OP_CM, 7'd0,  1'b0, 32'hA5A5_0F0F, 1'b1, 7'd2},
    '{OP_CM, 7'd0,  1'b0, 32'h1357_9BDF, 1'b1, 7'd9},
    '{OP_CM, 7'd0,  1'b0, 32'h1357_FFFF, 1'b1, 7'd9},
    '{OP_CM, 7'd0,  1'b0, 32'h2357_9BDF, 1'b0, 7'd0},
    '{OP_RD, 7'd9,  1'b0, 32'h1357_9BDF, 1'b0, 7'd0},
    '{OP_RD, 7'd9,  1'b1, 32'hFFFF_0000, 1'b0, 7'd0},
    '{OP_RD, 7'd3,  1'b1, 32'h0000_0000, 1'b0, 7'd0},
    '{OP_WR, 7'd40, 1'b1, 32'h0000_0000, 1'b0, 7'd0},
    '{OP_WR, 7'd40, 1'b0, 32'h0000_0000, 1'b0, 7'd0},
    '{OP_CM, 7'd0,  1'b0, 32'h2357_9BDF, 1'b1, 7'd40},
    '{OP_CM, 7'd0,  1'b0, 32'hA5A5_0F0F, 1'b1, 7'd2}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmp_req;
  logic [KEY_W-1:0] key_data;
  logic             wr_req;
  logic             rd_req;
  logic             plane_sel;
  logic [IDX_W-1:0] entry_idx;
  logic             cmp_ready;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic             rd_valid;
  logic [RD_W-1:0]  rd_data;
  logic             clash_err;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tcam_lookup_top u_tcam_lookup_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_req   (cmp_req),
    .key_data  (key_data),
    .wr_req    (wr_req),
    .rd_req    (rd_req),
    .plane_sel (plane_sel),
    .entry_idx (entry_idx),
    .cmp_ready (cmp_ready),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .clash_err (clash_err)
  );

  // widen a 32-bit seed to a full key by repeating it
  function automatic logic [KEY_W-1:0] spread(input logic [31:0] s);
    logic [KEY_W-1:0] r;
    for (int i = 0; i < KEY_W; i++) r[i] = s[i % 32];
    return r;
  endfunction

  function automatic logic [RD_W-1:0] padded(input logic [31:0] s);
    return {2'b11, spread(s)};
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cmp_req   = 1'b0;
    wr_req    = 1'b0;
    rd_req    = 1'b0;
    plane_sel = 1'b0;
    entry_idx = '0;
    key_data  = '0;
  endtask

  task automatic do_write(input logic [6:0] idx, input logic pl, input logic [31:0] seed);
    @(negedge clk);
    wr_req = 1'b1; plane_sel = pl; entry_idx = idx; key_data = spread(seed);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_read(input logic [6:0] idx, input logic pl, input logic [31:0] seed, input string tag);
    @(negedge clk);
    rd_req = 1'b1; plane_sel = pl; entry_idx = idx;
    @(negedge clk);
    chk({tag, " read strobe (R3)"}, 256'(rd_valid), 256'(1'b1));
    chk({tag, " read word and pad ones (R3 R4)"}, 256'(rd_data), 256'(padded(seed)));
    idle_inputs();
    @(negedge clk);
    chk({tag, " read strobe single cycle (R3)"}, 256'(rd_valid), 256'(1'b0));
  endtask

  task automatic do_compare(input logic [31:0] seed, input logic ehit, input logic [6:0] eidx, input string tag);
    @(negedge clk);
    cmp_req = 1'b1; key_data = spread(seed);
    @(negedge clk);
    chk({tag, " busy cycle (R8)"}, 256'(cmp_ready), 256'(1'b0));
    idle_inputs();
    @(negedge clk);
    chk({tag, " ready back (R8)"}, 256'(cmp_ready), 256'(1'b1));
    chk({tag, " hit flag (R5 R6 R11)"}, 256'(hit), 256'(ehit));
    chk({tag, " hit index (R5 R6 R11)"}, 256'(hit_idx), 256'(eidx));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1 ready in reset", 256'(cmp_ready), 256'(1'b1));
    chk("R1 hit in reset", 256'(hit), 256'(1'b0));
    chk("R1 hit_idx in reset", 256'(hit_idx), 256'(0));
    chk("R1 rd_valid in reset", 256'(rd_valid), 256'(1'b0));
    chk("R1 clash_err in reset", 256'(clash_err), 256'(1'b0));
    chk("R1 rd_data in reset (R4)", 256'(rd_data), 256'({2'b11, {KEY_W{1'b0}}}));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after release", 256'(cmp_ready), 256'(1'b1));

    // table walk: R2 R5 R6 R7 R11 plus reads for R3 R4
    for (int r = 0; r < NROWS; r++) begin
      string tag;
      tag = $sformatf("row %0d", r);
      case (TBL[r].op)
        OP_WR:   do_write(TBL[r].idx, TBL[r].plane, TBL[r].seed);
        OP_RD:   do_read(TBL[r].idx, TBL[r].plane, TBL[r].seed, {tag, " R2"});
        default: do_compare(TBL[r].seed, TBL[r].ehit, TBL[r].eidx, {tag, " R7"});
      endcase
    end

    // R8: result holds during busy cycle, then updates
    @(negedge clk);
    cmp_req = 1'b1; key_data = spread(32'h2357_9BDF);
    @(negedge clk);
    chk("R8 ready low in busy cycle", 256'(cmp_ready), 256'(1'b0));
    chk("R8 old index held in busy cycle", 256'(hit_idx), 256'(2));
    idle_inputs();
    @(negedge clk);
    chk("R8 new index presented", 256'(hit_idx), 256'(40));
    chk("R8 ready returns", 256'(cmp_ready), 256'(1'b1));

    // R9: second strobe during busy cycle ignored
    @(negedge clk);
    cmp_req = 1'b1; key_data = spread(32'hA5A5_0F0F);
    @(negedge clk);
    key_data = spread(32'h2357_9BDF);
    @(negedge clk);
    chk("R9 first search result", 256'(hit_idx), 256'(2));
    chk("R9 ready after first search", 256'(cmp_ready), 256'(1'b1));
    idle_inputs();
    @(negedge clk);
    chk("R9 busy strobe ignored, ready stays", 256'(cmp_ready), 256'(1'b1));
    chk("R9 busy strobe ignored, result kept", 256'(hit_idx), 256'(2));

    // R10: search and write in one cycle
    @(negedge clk);
    cmp_req = 1'b1; wr_req = 1'b1; plane_sel = 1'b1; entry_idx = 7'd1;
    key_data = spread(32'hC0DE_1234);
    @(negedge clk);
    chk("R10 clash flagged", 256'(clash_err), 256'(1'b1));
    chk("R10 search dropped", 256'(cmp_ready), 256'(1'b1));
    idle_inputs();
    @(negedge clk);
    chk("R10 clash pulse ends", 256'(clash_err), 256'(1'b0));
    chk("R10 result untouched", 256'(hit_idx), 256'(2));
    do_read(7'd1, 1'b1, 32'hC0DE_1234, "R10 write kept");

    // R3: read colliding with write returns old contents
    @(negedge clk);
    rd_req = 1'b1; wr_req = 1'b1; plane_sel = 1'b0; entry_idx = 7'd9;
    key_data = spread(32'h0BAD_F00D);
    @(negedge clk);
    chk("R3 read during write strobe", 256'(rd_valid), 256'(1'b1));
    chk("R3 read during write returns old word", 256'(rd_data), 256'(padded(32'h1357_9BDF)));
    idle_inputs();
    do_read(7'd9, 1'b0, 32'h0BAD_F00D, "R3 new word");

    // R1: second reset empties the table
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_compare(32'h2357_9BDF, 1'b0, 7'd0, "R1 entries emptied");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule